// File: doc/BRIEF.md
# Two-Round Keyed Byte-Substitution Permutation

This block applies two back-to-back rounds of an AES-style transform to a 128-bit word. Each round substitutes every byte through the standard AES S-box, rotates the rows of the 4x4 byte array by their standard offsets, multiplies every column by the standard GF(2^8) mixing matrix and finally XORs each of the sixteen bytes with its own byte of a round key. There is no key schedule: both round keys arrive on input ports beside the word.

Each round is a single combinational layer (sixteen substitution units and four column mixers working side by side) closed by a register, so the pair forms a two-stage pipeline. A word with its two keys is offered on a valid/ready input; the result leaves on a valid/ready output. With the output ready, a new word is taken every cycle.

Top module: `xround_pair`

## Requirements
- R1: After a synchronous reset, `res_valid` is 0 and `word_ready` is 1.
- R2: Every byte is replaced by the standard AES S-box value (0x00 maps to 0x63, 0x63 maps to 0xfb); an all-zero word with all-zero keys yields 0xfb in every byte.
- R3: Bytes are column-major: byte k occupies bits [127-8k -: 8], row k mod 4, column k div 4; row r is rotated left by r byte positions.
- R4: Each column is multiplied by the matrix with rows (2 3 1 1), (1 2 3 1), (1 1 2 3), (3 1 1 2) over GF(2^8) with reduction polynomial 0x11b.
- R5: Key addition XORs byte k of the state with byte k of the key; flipping bits in one byte of `key_b` flips exactly the same bits of the same output byte.
- R6: The first round uses `key_a`, the second round uses `key_b` captured with the same word.
- R7: A word accepted at clock edge e has its result on `res_word` with `res_valid` high after edge e+1.
- R8: With `res_ready` held high, one word is accepted and one result delivered per cycle, in order.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid` and `res_word` hold their values.
- R10: `word_ready` is low only while both pipeline stages are full and `res_ready` is low; no word is lost or duplicated under stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Input word and keys present |
| word_ready | output | 1 | Block can take a word this cycle |
| word_in | input | 128 | State word, byte 0 in the top byte |
| key_a | input | 128 | Round key for the first round |
| key_b | input | 128 | Round key for the second round |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_word | output | 128 | Two-round result |

## Verification
A result is due exactly two edges after acceptance: the bench drives inputs and samples outputs on the falling edge, confirms the output is still empty one falling edge after the accepting edge and compares the value one falling edge later. In a streaming run each result is checked at the falling edge two cycles after its word was offered, which also confirms one result per cycle. Under a stall the bench checks on every held cycle that the first result stays put and that the input refuses a third word, then checks that the queued results drain in order on consecutive cycles once the consumer is ready.

// File: rtl/xround_pkg.sv
package xround_pkg;
  localparam int BYTE_W   = 8;
  localparam int N_ROWS   = 4;
  localparam int N_COLS   = 4;
  localparam int N_BYTES  = N_ROWS * N_COLS;
  localparam int WORD_W   = N_BYTES * BYTE_W;
  localparam int COL_W    = N_ROWS * BYTE_W;
  localparam logic [BYTE_W-1:0] REDUCE = 8'h1b;
  localparam logic [BYTE_W-1:0] AFFINE_C = 8'h63;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic byte_t gf_dbl(input byte_t a);
    gf_dbl = {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? REDUCE : '0);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    gf_mul = acc;
  endfunction

  // multiplicative inverse as x^254 (0 maps to 0)
  function automatic byte_t gf_inv(input byte_t x);
    byte_t sq;
    byte_t r;
    sq = x;
    r  = 8'h01;
    for (int i = 1; i < BYTE_W; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    gf_inv = r;
  endfunction

  function automatic byte_t sbox_of(input byte_t x);
    byte_t v;
    v = gf_inv(x);
    sbox_of = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                ^ {v[3:0], v[7:4]} ^ AFFINE_C;
  endfunction

  function automatic int byte_lsb(input int k);
    byte_lsb = WORD_W - BYTE_W * (k + 1);
  endfunction
endpackage

// File: rtl/xr_sbox.sv
module xr_sbox
  import xround_pkg::*;
(
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);
  always_comb dout = sbox_of(din);
endmodule

// File: rtl/xr_colmix.sv
module xr_colmix
  import xround_pkg::*;
(
  input  logic [COL_W-1:0] cin,
  output logic [COL_W-1:0] cout
);
  byte_t b [N_ROWS];
  byte_t m [N_ROWS];

  for (genvar r = 0; r < N_ROWS; r++) begin : g_split
    assign b[r] = cin[COL_W-1-BYTE_W*r -: BYTE_W];
    assign cout[COL_W-1-BYTE_W*r -: BYTE_W] = m[r];
  end

  // row r: 2*b[r] ^ 3*b[r+1] ^ b[r+2] ^ b[r+3]
  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    always_comb begin
      m[r] = gf_dbl(b[r])
           ^ gf_dbl(b[(r+1)%N_ROWS]) ^ b[(r+1)%N_ROWS]
           ^ b[(r+2)%N_ROWS]
           ^ b[(r+3)%N_ROWS];
    end
  end
endmodule

// File: rtl/xr_round.sv
module xr_round
  import xround_pkg::*;
(
  input  logic [WORD_W-1:0] st_in,
  input  logic [WORD_W-1:0] rkey,
  output logic [WORD_W-1:0] st_out
);
  logic [WORD_W-1:0] subbed;
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] mixed;

  for (genvar k = 0; k < N_BYTES; k++) begin : g_sub
    xr_sbox u_sb (
      .din  (st_in [WORD_W-1-BYTE_W*k -: BYTE_W]),
      .dout (subbed[WORD_W-1-BYTE_W*k -: BYTE_W])
    );
  end

  // byte at (row r, col c) takes the byte from (row r, col c+r)
  for (genvar c = 0; c < N_COLS; c++) begin : g_shc
    for (genvar r = 0; r < N_ROWS; r++) begin : g_shr
      localparam int DST = c * N_ROWS + r;
      localparam int SRC = ((c + r) % N_COLS) * N_ROWS + r;
      assign shifted[WORD_W-1-BYTE_W*DST -: BYTE_W] =
             subbed[WORD_W-1-BYTE_W*SRC -: BYTE_W];
    end
  end

  for (genvar c = 0; c < N_COLS; c++) begin : g_mix
    xr_colmix u_cm (
      .cin  (shifted[WORD_W-1-COL_W*c -: COL_W]),
      .cout (mixed  [WORD_W-1-COL_W*c -: COL_W])
    );
  end

  assign st_out = mixed ^ rkey;
endmodule

// File: rtl/xround_pair.sv
module xround_pair
  import xround_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_in,
  input  logic [WORD_W-1:0] key_a,
  input  logic [WORD_W-1:0] key_b,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_word
);
  logic              mid_valid;
  logic [WORD_W-1:0] mid_word;
  logic [WORD_W-1:0] mid_key;
  logic [WORD_W-1:0] r1_out;
  logic [WORD_W-1:0] r2_out;
  logic              out_adv;
  logic              mid_adv;

  assign out_adv    = !res_valid || res_ready;
  assign mid_adv    = !mid_valid || out_adv;
  assign word_ready = mid_adv;

  xr_round u_r1 (.st_in(word_in),  .rkey(key_a),   .st_out(r1_out));
  xr_round u_r2 (.st_in(mid_word), .rkey(mid_key), .st_out(r2_out));

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_valid <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      if (mid_adv) mid_valid <= word_valid;
      if (out_adv) res_valid <= mid_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (mid_adv && word_valid) begin
      mid_word <= r1_out;
      mid_key  <= key_b;
    end
    if (out_adv && mid_valid) res_word <= r2_out;
  end
endmodule

// File: rtl/xround_pair_chk.sv
module xround_pair_chk
  import xround_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              word_valid,
  input logic              word_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [WORD_W-1:0] res_word
);
  assert_reset_empty_R1: assert property (@(posedge clk)
    rst |=> (!res_valid && word_ready));

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_ready) |=> ##1 res_valid);

  assert_hold_valid_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> res_valid);

  assert_hold_data_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> $stable(res_word));

  assert_stall_only_R10: assert property (@(posedge clk) disable iff (rst)
    !word_ready |-> (res_valid && !res_ready));
endmodule

bind xround_pair xround_pair_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_word   (res_word)
);

// File: tb/sim_xround_pair.sv
module sim_xround_pair;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         word_valid = 1'b0;
  logic         word_ready;
  logic [127:0] word_in = '0;
  logic [127:0] key_a = '0;
  logic [127:0] key_b = '0;
  logic         res_valid;
  logic         res_ready = 1'b1;
  logic [127:0] res_word;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xround_pair u0 (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_ready(word_ready),
    .word_in(word_in), .key_a(key_a), .key_b(key_b),
    .res_valid(res_valid), .res_ready(res_ready), .res_word(res_word)
  );

  // ---------------- software model ----------------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] inv = 0;
    logic [7:0] o;
    for (int c = 1; c < 256; c++)
      if (m_mul(x, 8'(c)) == 8'h01) inv = 8'(c);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
           ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
    return o;
  endfunction

  function automatic logic [127:0] m_round(input logic [127:0] s, input logic [127:0] k);
    logic [7:0] a [4][4];
    logic [7:0] t [4][4];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) a[i%4][i/4] = m_sbox(s[127-8*i -: 8]);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) t[r][c] = a[r][(c+r)%4];
    for (int c = 0; c < 4; c++) begin
      a[0][c] = m_mul(t[0][c],2) ^ m_mul(t[1][c],3) ^ t[2][c] ^ t[3][c];
      a[1][c] = t[0][c] ^ m_mul(t[1][c],2) ^ m_mul(t[2][c],3) ^ t[3][c];
      a[2][c] = t[0][c] ^ t[1][c] ^ m_mul(t[2][c],2) ^ m_mul(t[3][c],3);
      a[3][c] = m_mul(t[0][c],3) ^ t[1][c] ^ t[2][c] ^ m_mul(t[3][c],2);
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = a[i%4][i/4];
    return o ^ k;
  endfunction

  function automatic logic [127:0] m_pair(input logic [127:0] s,
      input logic [127:0] ka, input logic [127:0] kb);
    return m_round(m_round(s, ka), kb);
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one word, checks latency and value
  task automatic run_one(input logic [127:0] s, input logic [127:0] ka,
                         input logic [127:0] kb, input logic [127:0] exp,
                         input string tag);
    @(negedge clk);
    res_ready = 1'b1; word_valid = 1'b1; word_in = s; key_a = ka; key_b = kb;
    @(negedge clk);
    word_valid = 1'b0;
    check(res_valid == 1'b0, "R7 not early", 128'(res_valid), 128'(0));
    @(negedge clk);
    check(res_valid == 1'b1, "R7 due", 128'(res_valid), 128'(1));
    check(res_word == exp, tag, res_word, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(res_valid == 1'b0, "R1 res_valid", 128'(res_valid), 128'(0));
    check(word_ready == 1'b1, "R1 word_ready", 128'(word_ready), 128'(1));
  endtask

  task automatic t_zero;
    run_one('0, '0, '0, {16{8'hfb}}, "R2 zero word");
    run_one('0, '0, '0, m_pair('0, '0, '0), "R2 model zero");
  endtask

  task automatic t_known;
    run_one(128'h193de3bea0f4e22b9ac68d2ae9f84808,
            128'ha0fafe1788542cb123a339392a6c7605,
            128'hf2c295f27a96b9435935807a7359f67f,
            128'haa8f5f0361dde3ef82d24ad26832469a, "R4 R6 known vector");
  endtask

  task automatic t_model;
    logic [127:0] s = 128'h00112233445566778899aabbccddeeff;
    logic [127:0] ka = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    logic [127:0] kb = 128'hdeadbeef0123456789abcdeffedcba98;
    run_one(s, ka, kb, m_pair(s, ka, kb), "R3 model vec");
    run_one(128'h01 << 120, '0, '0, m_pair(128'h01 << 120, '0, '0), "R3 single byte");
    run_one(kb, s, ka, m_pair(kb, s, ka), "R4 model vec");
    // swapping the keys must change the result
    run_one(s, kb, ka, m_pair(s, kb, ka), "R6 key order");
  endtask

  task automatic t_keybyte;
    logic [127:0] s  = 128'h3243f6a8885a308d313198a2e0370734;
    logic [127:0] ka = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    logic [127:0] kb = 128'h0;
    logic [127:0] base = m_pair(s, ka, kb);
    logic [127:0] mask = 128'h5a << (127 - 8*5 - 7);
    run_one(s, ka, kb, base, "R5 base");
    run_one(s, ka, kb ^ mask, base ^ mask, "R5 one key byte");
  endtask

  task automatic t_stream;
    logic [127:0] w [6];
    logic [127:0] e [6];
    for (int i = 0; i < 6; i++) begin
      w[i] = {4{32'(i * 32'h9e3779b9 + 7)}};
      e[i] = m_pair(w[i], ~w[i], {w[i][63:0], w[i][127:64]});
    end
    res_ready = 1'b1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        check(res_valid == 1'b1, "R8 valid each cycle", 128'(res_valid), 128'(1));
        check(res_word == e[j-2], "R8 stream order", res_word, e[j-2]);
      end
      if (j < 6) begin
        check(word_ready == 1'b1, "R8 ready each cycle", 128'(word_ready), 128'(1));
        word_valid = 1'b1; word_in = w[j]; key_a = ~w[j];
        key_b = {w[j][63:0], w[j][127:64]};
      end else word_valid = 1'b0;
    end
  endtask

  task automatic t_stall;
    logic [127:0] w [3];
    logic [127:0] e [3];
    for (int i = 0; i < 3; i++) begin
      w[i] = 128'hc0ffee << (8 * i);
      e[i] = m_pair(w[i], 128'h1, 128'h2 << i);
    end
    @(negedge clk);
    res_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      word_valid = 1'b1; word_in = w[i]; key_a = 128'h1; key_b = 128'h2 << i;
      @(negedge clk);
    end
    // two words inside, third waiting
    for (int h = 0; h < 4; h++) begin
      check(word_ready == 1'b0, "R10 full stall", 128'(word_ready), 128'(0));
      check(res_valid == 1'b1, "R9 valid held", 128'(res_valid), 128'(1));
      check(res_word == e[0], "R9 data held", res_word, e[0]);
      @(negedge clk);
    end
    res_ready = 1'b1;
    check(res_word == e[0], "R10 first out", res_word, e[0]);
    @(negedge clk);
    word_valid = 1'b0;
    check(res_valid && res_word == e[1], "R10 second out", res_word, e[1]);
    @(negedge clk);
    check(res_valid && res_word == e[2], "R10 third out", res_word, e[2]);
    @(negedge clk);
    check(res_valid == 1'b0, "R10 no duplicate", 128'(res_valid), 128'(0));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_zero();
    t_known();
    t_model();
    t_keybyte();
    t_stream();
    t_stall();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", MAX_CYCLES);
    finish_run();
  end
endmodule